// File: doc/BRIEF.md
# Default Disk Geometry Calculator

This block takes a disk capacity, counted in sectors, and works out the default geometry that a drive reports when it is asked to identify itself. That geometry is a cylinder count, a head count and a sectors-per-track count. A one-cycle start pulse latches the capacity. The result registers then hold the last geometry until the next computation completes, and a one-cycle done pulse marks the moment new values appear.

Large capacities map straight to a fixed maximum geometry. Smaller capacities are resolved one dimension at a time. The sectors-per-track value is picked first. The head count is then derived from the capacity divided by that value, and the cylinder count from the capacity divided by the product of heads and sectors. Both divisions run on a single restoring divider that produces one quotient bit per clock. An empty disk skips division entirely.

Top module: `geo_chs_calc`

## Requirements
- R1: After reset, cylinders, heads and sectors read 0 and done is low.
- R2: A capacity of 16514064 sectors (16383 x 16 x 63) or more yields 16383 cylinders, 16 heads and 63 sectors.
- R3: Below that limit, sectors per track is 63 when the capacity is 63 or more, and equals the capacity otherwise.
- R4: Heads is the truncated quotient of capacity by sectors per track, saturated at 16.
- R5: Cylinders is the truncated quotient of capacity by the product of heads and sectors per track.
- R6: A capacity of 0 yields 0 for all three outputs, with no division performed.
- R7: For a capacity that needs division, done rises on the 67th rising edge counted from the edge that samples start (two 32-cycle divisions plus three control cycles). For a zero or clamped capacity, done rises on the very edge after the start edge.
- R8: Done is high for exactly one cycle. The three geometry outputs change only in the cycle where done is high, and otherwise hold their values.
- R9: A start pulse that arrives while a computation is in progress is ignored. The running computation finishes with its original capacity and its original timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to compute the geometry for `capacity` |
| capacity | input | 32 | Disk size in sectors, sampled when start is accepted |
| cylinders | output | 16 | Computed cylinder count |
| heads | output | 8 | Computed head count |
| sectors | output | 8 | Computed sectors per track |
| done | output | 1 | One-cycle pulse when new geometry is valid |

## Verification
Some properties are checked on every cycle. At each divider completion, the quotient and remainder must rebuild the dividend with a remainder below the divisor. The divider must never be given a zero divisor or a reload while it is busy. Done must be a single-cycle pulse, the outputs must stay still outside that pulse, the head count must never exceed 16, and the zero and clamp shortcuts must finish on the next edge. Only the bench scenarios can show that the saturation thresholds land at exactly 63 and 1008, that the end-to-end values match the geometry rules, that the 67-edge latency holds, and that a start arriving mid-computation leaves the result unchanged.

// File: rtl/geo_pkg.sv
package geo_pkg;
  localparam int CAP_W     = 32;
  localparam int CYL_W     = 16;
  localparam int GEO_W     = 8;
  localparam int MAX_CYL   = 16383;
  localparam int MAX_HEADS = 16;
  localparam int MAX_SPT   = 63;
  localparam logic [CAP_W-1:0] CLAMP_CAP = CAP_W'(MAX_CYL * MAX_HEADS * MAX_SPT);

  typedef logic [CAP_W-1:0] cap_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDIV = 2'd1,
    ST_CDIV = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [CAP_W-1:0] rem;
    logic             qbit;
  } div_step_t;

  // One restoring step: shift in the next dividend bit, subtract if it fits.
  function automatic div_step_t div_step(input cap_t rem, input logic msb, input cap_t dvs);
    logic [CAP_W:0] trial;
    div_step_t      r;
    trial = {rem, msb};
    if (trial >= {1'b0, dvs}) begin
      r.rem  = CAP_W'(trial - {1'b0, dvs});
      r.qbit = 1'b1;
    end else begin
      r.rem  = trial[CAP_W-1:0];
      r.qbit = 1'b0;
    end
    return r;
  endfunction

  function automatic logic is_clamped(input cap_t cap);
    return cap >= CLAMP_CAP;
  endfunction

  function automatic logic [GEO_W-1:0] pick_spt(input cap_t cap);
    return (cap >= cap_t'(MAX_SPT)) ? GEO_W'(MAX_SPT) : cap[GEO_W-1:0];
  endfunction

  function automatic logic [GEO_W-1:0] sat_heads(input cap_t q);
    return (q >= cap_t'(MAX_HEADS)) ? GEO_W'(MAX_HEADS) : q[GEO_W-1:0];
  endfunction

  function automatic cap_t track_span(input logic [GEO_W-1:0] hd, input logic [GEO_W-1:0] spt);
    return cap_t'(hd) * cap_t'(spt);
  endfunction
endpackage

// File: rtl/geo_div.sv
module geo_div
  import geo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  cap_t       dividend,
  input  cap_t       divisor,
  output logic       busy,
  output logic       fin,
  output cap_t       quotient
);
  localparam int CW = $clog2(CAP_W + 1);

  cap_t          rem_q, quo_q, dvs_q, dvd_q;
  logic [CW-1:0] cnt_q;
  div_step_t     nxt;
  logic          last_step;

  assign busy      = (cnt_q != '0);
  assign nxt       = div_step(rem_q, quo_q[CAP_W-1], dvs_q);
  assign last_step = busy && (cnt_q == CW'(1));
  assign quotient  = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      dvd_q <= '0;
      cnt_q <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        dvd_q <= dividend;
        cnt_q <= CW'(CAP_W);
      end else if (busy) begin
        rem_q <= nxt.rem;
        quo_q <= {quo_q[CAP_W-2:0], nxt.qbit};
        cnt_q <= cnt_q - CW'(1);
        if (last_step) fin <= 1'b1;
      end
    end
  end

  // R5: a finished division satisfies q*d + r == n with r < d
  a_r5_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (({{CAP_W{1'b0}}, quo_q} * {{CAP_W{1'b0}}, dvs_q} + {{CAP_W{1'b0}}, rem_q})
             == {{CAP_W{1'b0}}, dvd_q}) && (rem_q < dvs_q));
  // R6: never asked to divide by zero
  a_r6_no_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (divisor != '0));
  // R9: no reload while a division is running
  a_r9_no_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
  // R7: completion leaves the divider idle for the next operand
  a_r7_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> fin && !busy);
endmodule

// File: rtl/geo_seq.sv
module geo_seq
  import geo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  cap_t             capacity,
  input  logic             div_busy,
  input  logic             div_fin,
  input  cap_t             div_q,
  output logic             div_go,
  output cap_t             div_dvd,
  output cap_t             div_dvs,
  output logic [CYL_W-1:0] cylinders,
  output logic [GEO_W-1:0] heads,
  output logic [GEO_W-1:0] sectors,
  output logic             done
);
  seq_state_e       state_q;
  cap_t             cap_q;
  logic [GEO_W-1:0] spt_q, hd_q;
  logic [GEO_W-1:0] hd_now;
  logic             accept, take_zero, take_clamp, take_div;

  assign accept     = (state_q == ST_IDLE) && start;
  assign take_zero  = accept && (capacity == '0);
  assign take_clamp = accept && !take_zero && is_clamped(capacity);
  assign take_div   = accept && !take_zero && !take_clamp;
  assign hd_now     = sat_heads(div_q);

  always_comb begin
    div_go  = 1'b0;
    div_dvd = '0;
    div_dvs = '0;
    if (take_div) begin
      div_go  = 1'b1;
      div_dvd = capacity;
      div_dvs = cap_t'(pick_spt(capacity));
    end else if (state_q == ST_HDIV && div_fin) begin
      div_go  = 1'b1;
      div_dvd = cap_q;
      div_dvs = track_span(hd_now, spt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cap_q     <= '0;
      spt_q     <= '0;
      hd_q      <= '0;
      cylinders <= '0;
      heads     <= '0;
      sectors   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_zero) begin
            cylinders <= '0;
            heads     <= '0;
            sectors   <= '0;
            done      <= 1'b1;
          end else if (take_clamp) begin
            cylinders <= CYL_W'(MAX_CYL);
            heads     <= GEO_W'(MAX_HEADS);
            sectors   <= GEO_W'(MAX_SPT);
            done      <= 1'b1;
          end else if (take_div) begin
            cap_q   <= capacity;
            spt_q   <= pick_spt(capacity);
            state_q <= ST_HDIV;
          end
        end
        ST_HDIV: begin
          if (div_fin) begin
            hd_q    <= hd_now;
            state_q <= ST_CDIV;
          end
        end
        ST_CDIV: begin
          if (div_fin) begin
            cylinders <= div_q[CYL_W-1:0];
            heads     <= hd_q;
            sectors   <= spt_q;
            done      <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: outputs move only with done
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({cylinders, heads, sectors}));
  // R4: head count never above the saturation value
  a_r4_heads_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (heads <= GEO_W'(MAX_HEADS)));
  // R6: empty disk finishes next edge with zero geometry
  a_r6_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
    take_zero |=> done && cylinders == '0 && heads == '0 && sectors == '0);
  // R2: large disk finishes next edge with the fixed geometry
  a_r2_clamp_fast: assert property (@(posedge clk) disable iff (!rst_n)
    take_clamp |=> done && cylinders == CYL_W'(MAX_CYL)
                   && heads == GEO_W'(MAX_HEADS) && sectors == GEO_W'(MAX_SPT));
  // R9: latched capacity is untouched while a computation runs
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(cap_q));
  // R7: second division starts exactly as the first one ends
  a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDIV && div_fin) |-> div_go && !div_busy);
endmodule

// File: rtl/geo_chs_calc.sv
module geo_chs_calc
  import geo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      capacity,
  output logic [15:0]      cylinders,
  output logic [7:0]       heads,
  output logic [7:0]       sectors,
  output logic             done
);
  logic div_go, div_busy, div_fin;
  cap_t div_dvd, div_dvs, div_q;

  geo_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .capacity  (capacity),
    .div_busy  (div_busy),
    .div_fin   (div_fin),
    .div_q     (div_q),
    .div_go    (div_go),
    .div_dvd   (div_dvd),
    .div_dvs   (div_dvs),
    .cylinders (cylinders),
    .heads     (heads),
    .sectors   (sectors),
    .done      (done)
  );

  geo_div u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .busy     (div_busy),
    .fin      (div_fin),
    .quotient (div_q)
  );
endmodule

// File: tb/geo_chs_calc_tb_top.sv
module geo_chs_calc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_DIV    = 67;
  localparam int LAT_FAST   = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] capacity = '0;
  logic [15:0] cylinders;
  logic [7:0]  heads, sectors;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  geo_chs_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .capacity(capacity),
    .cylinders(cylinders), .heads(heads), .sectors(sectors), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference geometry, written from the rules in the brief
  task automatic ref_geo(input longint cap, output longint c, output longint h, output longint s,
                         output int lat);
    longint t;
    if (cap == 0) begin
      c = 0; h = 0; s = 0; lat = LAT_FAST;
    end else if (cap >= 64'd16383 * 64'd16 * 64'd63) begin
      c = 16383; h = 16; s = 63; lat = LAT_FAST;
    end else begin
      s = (cap < 63) ? cap : 63;
      t = cap / s;
      h = (t > 16) ? 16 : t;
      c = cap / (h * s);
      lat = LAT_DIV;
    end
  endtask

  task automatic run_case(input longint cap, input bit stray_start);
    longint ec, eh, es;
    int     elat;
    int     k;
    ref_geo(cap, ec, eh, es, elat);
    @(negedge clk);
    capacity = cap[31:0];
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 200) begin
      if (stray_start && k == 10) begin
        start = 1'b1; capacity = 32'd0;
      end else if (stray_start && k == 11) begin
        start = 1'b0; capacity = 32'd5;
      end
      @(negedge clk);
      k++;
    end
    if (stray_start) chk(k == elat, "R9 latency with stray start", k, elat);
    else             chk(k == elat, "R7 done latency", k, elat);
    chk(cylinders == ec[15:0], stray_start ? "R9 cylinders" : "R5 cylinders", cylinders, ec);
    chk(heads == eh[7:0],      "R4 heads", heads, eh);
    chk(sectors == es[7:0],    (cap >= 64'd16514064) ? "R2 sectors" : "R3 sectors", sectors, es);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    chk(cylinders == ec[15:0] && heads == eh[7:0] && sectors == es[7:0],
        "R8 outputs hold", {cylinders, heads, sectors}, {ec[15:0], eh[7:0], es[7:0]});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(cylinders == 0 && heads == 0 && sectors == 0, "R1 reset geometry",
        {cylinders, heads, sectors}, 0);
    chk(done == 0, "R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && cylinders == 0, "R1 idle after reset", done, 0);
  endtask

  task automatic t_zero();       run_case(0, 1'b0);                          endtask
  task automatic t_clamp();
    run_case(64'd16514064, 1'b0);
    run_case(64'hFFFF_FFFF, 1'b0);
  endtask
  task automatic t_small();
    run_case(1, 1'b0);
    run_case(62, 1'b0);
    run_case(63, 1'b0);
    run_case(100, 1'b0);
  endtask
  task automatic t_heads_edge();
    run_case(1007, 1'b0);
    run_case(1008, 1'b0);
  endtask
  task automatic t_large();
    run_case(1000000, 1'b0);
    run_case(64'd16514063, 1'b0);
  endtask
  task automatic t_busy();       run_case(1000000, 1'b1);                    endtask
  task automatic t_zero_after(); run_case(0, 1'b0); run_case(500, 1'b0);     endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog expired: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_clamp();
    t_small();
    t_heads_edge();
    t_large();
    t_busy();
    t_zero_after();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule